// File: doc/BRIEF.md
# CORDIC Sine/Cosine Engine

This block finds the cosine and sine of an angle with the CORDIC algorithm in rotation mode. It runs one shift-and-add micro-rotation per clock. A caller drives a signed 16-bit angle and raises `start` for one cycle while the engine is idle. Sixteen clocks later the block raises `done` for a single cycle. During that cycle `cos_q` carries the cosine and `sin_q` carries the sine.

Angles and results are two's-complement values with 14 fractional bits. A quarter turn (pi/2) is `0x6488`, and a unit result is `0x4000`. The starting vector is already scaled down by the CORDIC gain, so no gain correction is needed afterwards. The valid input range is -pi/2 to +pi/2. Internally the working registers carry four extra fraction bits, and the arctangent step for each micro-rotation comes from a small constant ROM.

Top module: `rot_sincos`

## Requirements
- R1: After reset, and before any operation has been started, `done` is 0 and both `cos_q` and `sin_q` are 0.
- R2: For any angle `a` in [-0x6488, +0x6488], where `a` is read as a / 2^14 radians, the cosine and sine results are each within 8 LSB of round(cos·2^14) and round(sin·2^14).
- R3: `done` goes high for exactly one cycle. It rises after the 16th rising clock edge that follows the edge at which `start` was accepted.
- R4: Whenever `done` is low, `cos_q` and `sin_q` read 0. This includes every cycle while the iterations are running.
- R5: While an operation is running, `start` is ignored. A pulse on `start` does not move the `done` cycle and does not change the result.
- R6: The angle is sampled only on the accepting edge. Changes on `angle` after that edge do not change the result.
- R7: A `start` given in the same cycle as `done` is accepted. The current result stays valid in that cycle, and the new operation completes 16 edges after its accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| arst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Request a new operation; taken only when idle |
| angle | input | 16 | Signed angle, 14 fractional bits, pi/2 = 0x6488 |
| done | output | 1 | One-cycle completion pulse |
| cos_q | output | 16 | Cosine, valid while `done` is high, otherwise 0 |
| sin_q | output | 16 | Sine, valid while `done` is high, otherwise 0 |

## Verification
Two events can fall in the same cycle: the completion pulse of one operation and the acceptance of the next `start`. The bench provokes this by raising `start` with a new angle in the very cycle `done` is high. It then checks three things. The first result is still correct in that cycle. `done` drops in the next cycle. The second result appears 16 edges after the accepting edge and matches its own angle within tolerance. Separate scenarios pulse `start` in the middle of a run and change `angle` just after acceptance, and both the latency and the result must stay unchanged.

// File: rtl/rot_sincos.sv
module rot_sincos #(
  parameter int DW = 16,
  parameter int GB = 4,
  parameter int IW = 4,
  parameter logic signed [DW-1:0] X_INIT = 'h26DD
) (
  input  logic                 clk,
  input  logic                 arst,
  input  logic                 start,
  input  logic signed [DW-1:0] angle,
  output logic                 done,
  output logic signed [DW-1:0] cos_q,
  output logic signed [DW-1:0] sin_q
);
  localparam int WW = DW + GB;
  localparam int LAST = (1 << IW) - 1;
  localparam logic signed [WW-1:0] MAX_W = WW'(2 ** (DW - 1) - 1);
  localparam logic signed [WW-1:0] MIN_W = -MAX_W - 1;

  function automatic logic signed [DW-1:0] atan_rom(input logic [IW-1:0] i);
    case (int'(i))
      0:  return DW'(12868);
      1:  return DW'(7596);
      2:  return DW'(4014);
      3:  return DW'(2037);
      4:  return DW'(1023);
      5:  return DW'(512);
      6:  return DW'(256);
      7:  return DW'(128);
      8:  return DW'(64);
      9:  return DW'(32);
      10: return DW'(16);
      11: return DW'(8);
      12: return DW'(4);
      13: return DW'(2);
      14: return DW'(1);
      default: return '0;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] narrow(input logic signed [WW-1:0] v);
    logic signed [WW-1:0] s;
    s = v >>> GB;
    if (s > MAX_W)      return {1'b0, {(DW-1){1'b1}}};
    else if (s < MIN_W) return {1'b1, {(DW-1){1'b0}}};
    else                return s[DW-1:0];
  endfunction

  logic                 busy, fin, fin_d;
  logic [IW-1:0]        idx;
  logic signed [WW-1:0] x_r, y_r, z_r;

  logic signed [WW-1:0] xs, ys, at_w;
  logic                 neg;

  assign xs   = x_r >>> idx;
  assign ys   = y_r >>> idx;
  assign at_w = WW'(atan_rom(idx)) <<< GB;
  assign neg  = z_r[WW-1];

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      busy  <= 1'b0;
      fin   <= 1'b0;
      fin_d <= 1'b0;
      idx   <= '0;
      x_r   <= '0;
      y_r   <= '0;
      z_r   <= '0;
    end else begin
      fin_d <= fin;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          fin  <= 1'b0;
          idx  <= '0;
          x_r  <= WW'(X_INIT) <<< GB;
          y_r  <= '0;
          z_r  <= WW'(angle) <<< GB;
        end
      end else begin
        x_r <= neg ? x_r + ys : x_r - ys;
        y_r <= neg ? y_r - xs : y_r + xs;
        z_r <= neg ? z_r + at_w : z_r - at_w;
        idx <= idx + 1'b1;
        if (idx == IW'(LAST)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign done  = fin & ~fin_d;
  assign cos_q = done ? narrow(x_r) : '0;
  assign sin_q = done ? narrow(y_r) : '0;

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (arst)
    done |=> !done);

  p_done_after_run_r3: assert property (@(posedge clk) disable iff (arst)
    done |-> (!busy && $past(busy)));

  p_quiet_busy_r4: assert property (@(posedge clk) disable iff (arst)
    busy |-> (!done && cos_q == '0 && sin_q == '0));

  p_busy_ignores_start_r5: assert property (@(posedge clk) disable iff (arst)
    (busy && start && idx != IW'(LAST)) |=> (busy && idx == $past(idx) + 1'b1));

  p_accept_idle_r6: assert property (@(posedge clk) disable iff (arst)
    (!busy && start) |=> (busy && idx == '0));

  p_residual_small_r2: assert property (@(posedge clk) disable iff (arst)
    done |-> (z_r >= -WW'(256) && z_r <= WW'(256)));

endmodule

// File: tb/test_rot_sincos.sv
module test_rot_sincos;
  logic        clk = 1'b0;
  logic        arst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] angle = '0;
  logic        done;
  logic [15:0] cos_q, sin_q;

  int checks = 0;
  int fails = 0;
  bit reported = 1'b0;

  always #10 clk = ~clk;

  rot_sincos i_rot_sincos (
    .clk(clk), .arst(arst), .start(start), .angle(angle),
    .done(done), .cos_q(cos_q), .sin_q(sin_q)
  );

  function automatic int ref_q(input int a, input bit want_sin);
    real r, v;
    r = real'(a) / 16384.0;
    v = (want_sin ? $sin(r) : $cos(r)) * 16384.0;
    return $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_near(input string req, input string what, input int act, input int exp);
    int d;
    d = act - exp;
    if (d < 0) d = -d;
    checks++;
    if (d > 8) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (+/-8)", req, what, act, exp);
    end
  endtask

  task automatic check_result(input string req, input int a);
    check_eq("R3", "done at completion", int'(done), 1);
    check_near(req, $sformatf("cos(%0d)", a), int'($signed(cos_q)), ref_q(a, 1'b0));
    check_near(req, $sformatf("sin(%0d)", a), int'($signed(sin_q)), ref_q(a, 1'b1));
  endtask

  task automatic check_idle_out(input string what);
    check_eq("R3", {what, " done"}, int'(done), 0);
    check_eq("R4", {what, " cos"}, int'(cos_q), 0);
    check_eq("R4", {what, " sin"}, int'(sin_q), 0);
  endtask

  // mode 0: plain; 1: extra start mid-run (R5); 2: angle changed after accept (R6)
  task automatic do_op(input int a, input int mode, input string req);
    bit quiet;
    quiet = 1'b1;
    @(negedge clk);
    start = 1'b1;
    angle = 16'(a);
    @(posedge clk);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (done || cos_q != 0 || sin_q != 0) quiet = 1'b0;
      if (k == 0) begin
        start = 1'b0;
        if (mode == 2) angle = 16'(-a + 3000);
      end
      if (mode == 1 && k == 5) begin
        start = 1'b1;
        angle = 16'h1922;
      end
      if (mode == 1 && k == 6) start = 1'b0;
    end
    check_eq("R4", "outputs quiet during run", int'(quiet), 1);
    @(negedge clk);
    check_result(req, a);
    @(negedge clk);
    check_idle_out("after pulse");
  endtask

  task automatic t_reset;
    arst = 1'b1;
    repeat (3) @(negedge clk);
    arst = 1'b0;
    @(negedge clk);
    check_idle_out("R1 reset");
    check_eq("R1", "reset done", int'(done), 0);
  endtask

  task automatic t_corners;
    do_op(0, 0, "R2");
    do_op(16'sh6488, 0, "R2");
    do_op(16'sh3244, 0, "R2");
    do_op(16'sh1922, 0, "R2");
    do_op(-16'sh1922, 0, "R2");
    do_op(-16'sh3244, 0, "R2");
    do_op(-16'sh6488, 0, "R2");
  endtask

  task automatic t_sweep;
    for (int a = -25736; a <= 25736; a += 1777) do_op(a, 0, "R2");
  endtask

  task automatic t_start_while_busy;
    do_op(-9000, 1, "R5");
  endtask

  task automatic t_angle_change;
    do_op(7000, 2, "R6");
  endtask

  task automatic t_back_to_back;
    bit quiet;
    quiet = 1'b1;
    @(negedge clk);
    start = 1'b1;
    angle = 16'(5000);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (done || cos_q != 0 || sin_q != 0) quiet = 1'b0;
    end
    check_eq("R7", "first run quiet", int'(quiet), 1);
    @(negedge clk);
    check_result("R7", 5000);
    start = 1'b1;
    angle = 16'(-20000);
    @(negedge clk);
    start = 1'b0;
    check_idle_out("R7 cycle after chained pulse");
    quiet = 1'b1;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (done || cos_q != 0 || sin_q != 0) quiet = 1'b0;
    end
    check_eq("R7", "second run quiet", int'(quiet), 1);
    @(negedge clk);
    check_result("R7", -20000);
    @(negedge clk);
    check_idle_out("R7 end");
  endtask

  task automatic report;
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_sweep();
    t_start_while_busy();
    t_angle_change();
    t_back_to_back();
    report();
    $finish;
  end
endmodule